// File: doc/BRIEF.md
# Bit-Split Parallel Multi-Pattern Matcher

This block scans a stream of 5-bit characters for a set of patterns at once. A single automaton over the full character alphabet would need a wide transition table. Here it is replaced by five small binary automata, called lanes. Lane i looks only at bit i of each character. Each of its states therefore needs just two next-state entries and a vector with one bit per pattern. A set bit in that vector marks a pattern that may end in that state. All five lanes advance together on every accepted character. A pattern is reported only when every lane agrees on it, so the result is the bitwise AND of the five vectors that belong to the states the lanes have just entered.

The tables are built offline and written in through a load port while the character stream is idle. Each write fills one whole state row of one lane: both next states and the pattern vector. When the AND result is non-zero, a one-cycle pulse comes out together with the result vector and the zero-based offset of the character that completed the match.

Top module: `bitsplit_matcher`

## Requirements
- R1: Lane i (0 to 4) takes its transition from bit i of `in_char`. On each accepted character (`in_valid` high), every lane moves from its current state to `next1` of that state when its bit is 1, or to `next0` when its bit is 0.
- R2: A write with `cfg_we` high and `in_valid` low stores `cfg_next0`, `cfg_next1` and `cfg_vec` as the row of state `cfg_state` in the lane numbered by `cfg_lane`. The write takes effect for characters accepted from the next cycle on.
- R3: A write attempted while `in_valid` is high changes no table.
- R4: After reset, every lane is in state 0 and `match_valid`, `match_vec` and the offset counter are zero. Table contents are kept across reset.
- R5: One cycle after a character is accepted, `match_vec` equals the AND of the five pattern vectors of the states the lanes entered. `match_valid` is high exactly when that AND is non-zero, and bit p of `match_vec` stands for pattern p.
- R6: `match_pos`, updated one cycle after each accepted character, holds that character's zero-based offset among the characters accepted since reset, wrapping at 2^POS_W.
- R7: A cycle with `in_valid` low leaves every lane state and `match_pos` unchanged, and in the following cycle `match_valid` is low.
- R8: `match_vec` is all zeros whenever `match_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table row write strobe, honoured only while `in_valid` is low |
| cfg_lane | input | LANE_W | Lane to write (0 to 4) |
| cfg_state | input | SW | State row to write |
| cfg_next0 | input | SW | Next state when the lane bit is 0 |
| cfg_next1 | input | SW | Next state when the lane bit is 1 |
| cfg_vec | input | NUM_PAT | Partial pattern vector of the row |
| in_valid | input | 1 | Character accepted this cycle |
| in_char | input | CHAR_BITS | Input character |
| match_valid | output | 1 | Match pulse |
| match_vec | output | NUM_PAT | Patterns matched at the reported character |
| match_pos | output | POS_W | Offset of the reported character |

## Verification
The bench builds the block with four states per lane, three patterns and an 8-bit offset. With these values it can write every row of every lane and drive all 32 character codes from many different lane-state combinations. Two arithmetic table families are used. One makes partial AND results frequent, and the other routes many transitions back to state 0. Further runs cover writes attempted during streaming, idle gaps between characters, and a reset taken after the tables are loaded.

// File: rtl/bsm_pkg.sv
// Package: shared defaults for the bit-split matcher.
// Assumes: a character is at most eight bits wide.
package bsm_pkg;
    parameter int unsigned DEF_CHAR_BITS = 5;
    parameter int unsigned DEF_NUM_PAT   = 3;
    parameter int unsigned DEF_NSTATES   = 16;
    parameter int unsigned DEF_POS_W     = 16;

    // Width needed to hold a lane index below n.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/bsm_lane.sv
// Module: one binary automaton lane.
// Holds the per-state rows (two next states and a pattern vector) and the
// current state. Assumes writes never coincide with a step (gated above).
module bsm_lane #(
    parameter int unsigned NSTATES = 16,
    parameter int unsigned NUM_PAT = 3,
    parameter int unsigned SW      = $clog2(NSTATES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SW-1:0]      wr_state,
    input  logic [SW-1:0]      wr_next0,
    input  logic [SW-1:0]      wr_next1,
    input  logic [NUM_PAT-1:0] wr_vec,
    input  logic               step,
    input  logic               bit_in,
    output logic [NUM_PAT-1:0] next_vec
);
    logic [SW-1:0]      zero_tab [NSTATES];
    logic [SW-1:0]      one_tab  [NSTATES];
    logic [NUM_PAT-1:0] vec_tab  [NSTATES];
    logic [SW-1:0]      cur_q;
    logic [SW-1:0]      nxt;

    // Row storage: written whole; not cleared by reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            zero_tab[wr_state] <= wr_next0;
            one_tab[wr_state]  <= wr_next1;
            vec_tab[wr_state]  <= wr_vec;
        end
    end

    // Pick the successor from this lane's bit and fetch its vector.
    always_comb begin
        nxt      = bit_in ? one_tab[cur_q] : zero_tab[cur_q];
        next_vec = vec_tab[nxt];
    end

    // Current state: back to 0 on reset, advances on each accepted character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (step) begin
            cur_q <= nxt;
        end
    end
endmodule

// File: rtl/bsm_collect.sv
// Module: AND reduction across lanes and registered match report.
// Assumes lane vectors are packed lane 0 in the low bits.
module bsm_collect #(
    parameter int unsigned LANES   = 5,
    parameter int unsigned NUM_PAT = 3,
    parameter int unsigned POS_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic [LANES*NUM_PAT-1:0] lane_vecs,
    output logic                     match_valid,
    output logic [NUM_PAT-1:0]       match_vec,
    output logic [POS_W-1:0]         match_pos
);
    logic [NUM_PAT-1:0] hit;
    logic [POS_W-1:0]   pos_cnt;

    // Combine the partial vectors of all lanes.
    always_comb begin
        hit = '1;
        for (int i = 0; i < LANES; i++) begin
            hit &= lane_vecs[i*NUM_PAT +: NUM_PAT];
        end
    end

    // Register the report and count accepted characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_valid <= 1'b0;
            match_vec   <= '0;
            match_pos   <= '0;
            pos_cnt     <= '0;
        end else if (step) begin
            match_valid <= |hit;
            match_vec   <= hit;
            match_pos   <= pos_cnt;
            pos_cnt     <= pos_cnt + 1'b1;
        end else begin
            match_valid <= 1'b0;
            match_vec   <= '0;
        end
    end
endmodule

// File: rtl/bitsplit_matcher.sv
// Module: top of the bit-split multi-pattern matcher.
// One binary lane per character bit, all stepping together; the report is
// the AND of the lanes' vectors. Assumes tables are loaded while idle.
module bitsplit_matcher
    import bsm_pkg::*;
#(
    parameter int unsigned CHAR_BITS = DEF_CHAR_BITS,
    parameter int unsigned NUM_PAT   = DEF_NUM_PAT,
    parameter int unsigned NSTATES   = DEF_NSTATES,
    parameter int unsigned POS_W     = DEF_POS_W,
    parameter int unsigned SW        = $clog2(NSTATES),
    parameter int unsigned LANE_W    = idx_width(CHAR_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [LANE_W-1:0]    cfg_lane,
    input  logic [SW-1:0]        cfg_state,
    input  logic [SW-1:0]        cfg_next0,
    input  logic [SW-1:0]        cfg_next1,
    input  logic [NUM_PAT-1:0]   cfg_vec,
    input  logic                 in_valid,
    input  logic [CHAR_BITS-1:0] in_char,
    output logic                 match_valid,
    output logic [NUM_PAT-1:0]   match_vec,
    output logic [POS_W-1:0]     match_pos
);
    logic [CHAR_BITS*NUM_PAT-1:0] lane_vecs;
    logic                         load_ok;

    // Writes are honoured only while no character is being accepted.
    always_comb load_ok = cfg_we && !in_valid;

    for (genvar g = 0; g < CHAR_BITS; g++) begin : g_lane
        logic sel;
        // Lane-select decode for this lane's write port.
        always_comb sel = load_ok && (cfg_lane == LANE_W'(g));

        bsm_lane #(
            .NSTATES (NSTATES),
            .NUM_PAT (NUM_PAT),
            .SW      (SW)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel),
            .wr_state (cfg_state),
            .wr_next0 (cfg_next0),
            .wr_next1 (cfg_next1),
            .wr_vec   (cfg_vec),
            .step     (in_valid),
            .bit_in   (in_char[g]),
            .next_vec (lane_vecs[g*NUM_PAT +: NUM_PAT])
        );
    end

    bsm_collect #(
        .LANES   (CHAR_BITS),
        .NUM_PAT (NUM_PAT),
        .POS_W   (POS_W)
    ) u_collect (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (in_valid),
        .lane_vecs   (lane_vecs),
        .match_valid (match_valid),
        .match_vec   (match_vec),
        .match_pos   (match_pos)
    );
endmodule

// File: rtl/bsm_checker.sv
// Module: temporal checks on the matcher's ports, bound to the top.
// Assumes the synchronous active-low reset of the top.
module bsm_checker #(
    parameter int unsigned NUM_PAT = 3,
    parameter int unsigned POS_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               match_valid,
    input logic [NUM_PAT-1:0] match_vec,
    input logic [POS_W-1:0]   match_pos
);
    // R4
    after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!match_valid && match_vec == '0 && match_pos == '0));

    // R5
    pulse_has_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> (match_vec != '0));

    // R8
    quiet_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid |-> (match_vec == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!match_valid && $stable(match_pos)));

    // R6
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(in_valid) && $past(rst_n)) |=>
            (match_pos == POS_W'($past(match_pos) + 1'b1)));
endmodule

bind bitsplit_matcher bsm_checker #(
    .NUM_PAT (NUM_PAT),
    .POS_W   (POS_W)
) u_bsm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .match_valid (match_valid),
    .match_vec   (match_vec),
    .match_pos   (match_pos)
);

// File: tb/bitsplit_matcher_test.sv
module bitsplit_matcher_test;
    localparam int CB = 5;
    localparam int NP = 3;
    localparam int NS = 4;
    localparam int PW = 8;
    localparam int SWB = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [2:0]     cfg_lane = '0;
    logic [SWB-1:0] cfg_state = '0;
    logic [SWB-1:0] cfg_next0 = '0;
    logic [SWB-1:0] cfg_next1 = '0;
    logic [NP-1:0]  cfg_vec = '0;
    logic           in_valid = 1'b0;
    logic [CB-1:0]  in_char = '0;
    logic           match_valid;
    logic [NP-1:0]  match_vec;
    logic [PW-1:0]  match_pos;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_n0  [CB][NS];
    int m_n1  [CB][NS];
    int m_vec [CB][NS];
    int m_st  [CB];
    int m_pos = 0;

    bitsplit_matcher #(
        .CHAR_BITS (CB), .NUM_PAT (NP), .NSTATES (NS), .POS_W (PW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_lane (cfg_lane),
        .cfg_state (cfg_state), .cfg_next0 (cfg_next0), .cfg_next1 (cfg_next1),
        .cfg_vec (cfg_vec), .in_valid (in_valid), .in_char (in_char),
        .match_valid (match_valid), .match_vec (match_vec), .match_pos (match_pos)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // R2: whole-row write while idle
    task automatic wr_row(input int l, input int s, input int a, input int b, input int v);
        cfg_we = 1'b1; cfg_lane = 3'(l); cfg_state = SWB'(s);
        cfg_next0 = SWB'(a); cfg_next1 = SWB'(b); cfg_vec = NP'(v);
        in_valid = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        m_n0[l][s] = a; m_n1[l][s] = b; m_vec[l][s] = v;
    endtask

    task automatic load_family(input int fam);
        for (int l = 0; l < CB; l++) begin
            for (int s = 0; s < NS; s++) begin
                int a, b, v;
                if (fam == 0) begin
                    a = (3*s + l + 1) % NS;
                    b = (s + 2*l + 3) % NS;
                    v = ((s + l) % 4 == 3) ? 7 : (7 & ~(1 << ((s + l) % 4)));
                end else begin
                    a = (l % 2 == 0) ? (s + 1) % NS : 0;
                    b = (l % NS == s) ? (s + 1) % NS : 0;
                    v = (s == 3) ? 5 : ((s == 0) ? 6 : 7);
                end
                wr_row(l, s, a, b, v);
            end
        end
    endtask

    // R1 R5 R6: accept one character and compare the report a cycle later
    task automatic send(input int ch, input bit try_wr);
        int acc;
        int ep;
        in_valid = 1'b1; in_char = CB'(ch);
        if (try_wr) begin
            // R3: write attempted while streaming
            cfg_we = 1'b1; cfg_lane = 3'(ch % CB); cfg_state = SWB'(ch % NS);
            cfg_next0 = SWB'(~m_n0[ch % CB][ch % NS]);
            cfg_next1 = SWB'(~m_n1[ch % CB][ch % NS]);
            cfg_vec = NP'(~m_vec[ch % CB][ch % NS]);
        end
        acc = 7;
        for (int l = 0; l < CB; l++) begin
            m_st[l] = ((ch >> l) & 1) ? m_n1[l][m_st[l]] : m_n0[l][m_st[l]];
            acc &= m_vec[l][m_st[l]];
        end
        ep = m_pos % (1 << PW);
        m_pos++;
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        check(match_vec == NP'(acc), try_wr ? "R3 R5 vec" : "R1 R5 vec", int'(match_vec), acc);
        check(match_valid == (acc != 0), "R5 valid", int'(match_valid), int'(acc != 0));
        check(match_pos == PW'(ep), "R6 pos", int'(match_pos), ep);
    endtask

    // R7 R8: idle cycle
    task automatic idle();
        logic [PW-1:0] p;
        p = match_pos;
        in_valid = 1'b0;
        @(negedge clk);
        check(!match_valid, "R7 valid low", int'(match_valid), 0);
        check(match_vec == '0, "R8 vec zero", int'(match_vec), 0);
        check(match_pos == p, "R7 pos held", int'(match_pos), int'(p));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int l = 0; l < CB; l++) m_st[l] = 0;
        m_pos = 0;
        @(negedge clk);
        check(!match_valid, "R4 valid", int'(match_valid), 0);
        check(match_vec == '0, "R4 vec", int'(match_vec), 0);
        check(match_pos == '0, "R4 pos", int'(match_pos), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int l = 0; l < CB; l++) m_st[l] = 0;
        @(negedge clk);
        do_reset();
        load_family(0);
        // ascending sweep, back to back
        for (int c = 0; c < 32; c++) send(c, 1'b0);
        // permuted sweep with idle gaps
        for (int c = 0; c < 32; c++) begin
            send((c*7 + 3) % 32, 1'b0);
            if (c % 5 == 0) idle();
        end
        // R3: writes offered during streaming must be dropped
        for (int c = 0; c < 20; c++) send((c*13 + 1) % 32, 1'b1);
        for (int c = 0; c < 32; c++) send(31 - c, 1'b0);
        // R4: reset keeps tables; lanes restart from state 0
        do_reset();
        for (int c = 0; c < 64; c++) send((c*11 + 5) % 32, 1'b0);
        // R2: reload a second family mid-stream
        load_family(1);
        for (int c = 0; c < 96; c++) begin
            send((c*3 + (c / 32)) % 32, 1'b0);
            if (c % 9 == 4) idle();
        end
        // R6: offset wraps past 2^POS_W
        for (int c = 0; c < 300; c++) send(c % 32, 1'b0);
        idle();
        finish_run();
    end
endmodule